// File: doc/BRIEF.md
# Hysteresis Threshold Compare Bank

This block holds eight digital compare channels. They are grouped as two front-ends of four channels each. Every channel keeps its last result bit and owns two programmable 12-bit threshold codes. When the channel's sample strobe fires, the channel reads its own previous result and uses it to pick one of its two thresholds. It compares the incoming sample against that threshold and registers the outcome as its new result. Because the threshold follows the previous result, a slow or noisy input does not chatter around a single level. The pair of codes sets a low trip point and a high trip point, and each channel can be trimmed on its own.

A timing sequencer outside the block supplies the strobes and two switch signals, one for the comparator path and one for the reference path. The second front-end has two further local enables, and it is only active when both are set. The first front-end has a test input that makes all four of its channels share its top pair of threshold codes. Software loads the thresholds through a small write port, using a 4-bit address.

Top module: `hyst_cmp_bank`

## Requirements
- R1: While reset is asserted, and after it, all eight result bits are 0 and every threshold code is 0. As a result, the first strobed compare after reset, with both front-ends enabled, returns 1 for any sample, including a sample of 0.
- R2: Result bit i is channel i. Its sample is `samp_data[12*i +: 12]`. Bits 0–3 are front-end 1 (channel index k = i) and bits 4–7 are front-end 2 (k = i−4).
- R3: A write with `cfg_we`=1 stores `cfg_wdata` into the threshold code chosen by the address. `cfg_addr[3]` picks the front-end (0 = first, 1 = second) and `cfg_addr[2:0]` picks the code index 0–7. A strobe in the same cycle as the write still compares against the old code. Later strobes use the new code.
- R4: When test mode is off, channel k uses code index 2k of its front-end if its stored result is 0, and code index 2k+1 if its stored result is 1.
- R5: A strobed, enabled channel stores 1 when its sample, taken as unsigned, is greater than or equal to the selected code, and stores 0 otherwise. The new value appears on `result` after the clock edge at which the strobe is sampled high.
- R6: A channel whose strobe is low keeps its result unchanged.
- R7: Front-end 1 updates only when `seq_cmp_on` and `seq_dac_on` are both 1. If either is 0, its strobes have no effect.
- R8: Front-end 2 updates only when `fe2_cmp_en`, `fe2_dac_en`, `seq_cmp_on` and `seq_dac_on` are all 1. Clearing either local enable freezes front-end 2 while front-end 1 keeps working.
- R9: When `tst_ovr`=1, every front-end 1 channel uses code index 6 if its stored result is 0 and code index 7 if its stored result is 1. Front-end 2 keeps its normal per-channel selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| samp_strb | input | 8 | Per-channel sample strobe |
| samp_data | input | 96 | Eight packed 12-bit samples, channel i at bits 12*i+11:12*i |
| seq_cmp_on | input | 1 | Sequencer comparator enable, shared by both front-ends |
| seq_dac_on | input | 1 | Sequencer reference enable, shared by both front-ends |
| fe2_cmp_en | input | 1 | Local comparator enable of front-end 2 |
| fe2_dac_en | input | 1 | Local reference enable of front-end 2 |
| tst_ovr | input | 1 | Test override of front-end 1 threshold selection |
| cfg_we | input | 1 | Threshold write enable |
| cfg_addr | input | 4 | Threshold address: bit 3 front-end, bits 2:0 code index |
| cfg_wdata | input | 12 | Threshold write data |
| result | output | 8 | Stored compare results |

## Verification
A threshold write and a strobed compare can land in the same cycle on the very code that the compare selects. The bench provokes this by writing a channel's active code in the same cycle as that channel's strobe, with a sample that lies between the old and the new code. Its reference model evaluates every compare against the thresholds as they stood before the write and only then applies the write. This way, reading the new value too early shows up as a wrong result bit one cycle later. A second overlap, a strobe together with a toggle of the test override, is judged the same way, and the model picks the code pair from the override value in that cycle.

// File: rtl/hyst_cmp_pkg.sv
package hyst_cmp_pkg;
  localparam int unsigned DATA_W_DEF    = 12;
  localparam int unsigned CH_PER_FE_DEF = 4;
  localparam int unsigned NUM_FE_DEF    = 2;

  typedef struct packed {
    logic cmp_on;
    logic dac_on;
  } fe_ctl_t;
endpackage

// File: rtl/hyst_rst_sync.sv
module hyst_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/hyst_ref_bank.sv
module hyst_ref_bank #(
  parameter  int unsigned DW    = 12,
  parameter  int unsigned NREG  = 8,
  parameter  int unsigned NFE   = 2,
  parameter  int unsigned FE_ID = 0,
  localparam int unsigned IW    = $clog2(NREG),
  localparam int unsigned SW    = (NFE > 1) ? $clog2(NFE) : 1,
  localparam int unsigned AW    = SW + IW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [NREG*DW-1:0] ref_flat
);
  localparam logic [SW-1:0] MY_SEL = SW'(FE_ID);

  logic bank_hit;

  always_comb begin
    bank_hit = we && (addr[AW-1:IW] == MY_SEL);
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic          wr_en;
    logic [DW-1:0] code_q;

    always_comb begin
      wr_en = bank_hit && (addr[IW-1:0] == IW'(r));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q <= '0;
      end else if (wr_en) begin
        code_q <= wdata;
      end
    end

    assign ref_flat[r*DW +: DW] = code_q;
  end
endmodule

// File: rtl/hyst_fe_gate.sv
module hyst_fe_gate
  import hyst_cmp_pkg::*;
#(
  parameter bit HAS_LOCAL_EN = 1'b0
) (
  input  fe_ctl_t seq_ctl,
  input  fe_ctl_t loc_en,
  output logic    act
);
  fe_ctl_t eff;

  always_comb begin
    eff.cmp_on = seq_ctl.cmp_on & (HAS_LOCAL_EN ? loc_en.cmp_on : 1'b1);
    eff.dac_on = seq_ctl.dac_on & (HAS_LOCAL_EN ? loc_en.dac_on : 1'b1);
    act        = eff.cmp_on & eff.dac_on;
  end
endmodule

// File: rtl/hyst_channel.sv
module hyst_channel #(
  parameter  int unsigned DW          = 12,
  parameter  int unsigned NREG        = 8,
  parameter  int unsigned CH_K        = 0,
  parameter  bit          TST_CAPABLE = 1'b0,
  localparam int unsigned IW          = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREG*DW-1:0] ref_flat,
  input  logic [DW-1:0]      sample,
  input  logic               stb,
  input  logic               act,
  input  logic               tst,
  output logic               res
);
  logic          ovr;
  logic          upd;
  logic [IW-1:0] base_idx;
  logic [IW-1:0] sel_idx;
  logic [DW-1:0] ref_sel;
  logic          res_d;

  always_comb begin
    ovr      = TST_CAPABLE && tst;
    base_idx = ovr ? IW'(NREG - 2) : IW'(2 * CH_K);
    sel_idx  = base_idx | IW'(res);
    ref_sel  = ref_flat[int'(sel_idx) * DW +: DW];
    upd      = stb && act;
    res_d    = upd ? (sample >= ref_sel) : res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= 1'b0;
    end else if (upd) begin
      res <= res_d;
    end
  end
endmodule

// File: rtl/hyst_cmp_bank.sv
module hyst_cmp_bank
  import hyst_cmp_pkg::*;
#(
  parameter  int unsigned DW   = DATA_W_DEF,
  parameter  int unsigned CPF  = CH_PER_FE_DEF,
  parameter  int unsigned NFE  = NUM_FE_DEF,
  localparam int unsigned NCH  = CPF * NFE,
  localparam int unsigned NREG = 2 * CPF,
  localparam int unsigned IW   = $clog2(NREG),
  localparam int unsigned SW   = (NFE > 1) ? $clog2(NFE) : 1,
  localparam int unsigned AW   = SW + IW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    samp_strb,
  input  logic [NCH*DW-1:0] samp_data,
  input  logic              seq_cmp_on,
  input  logic              seq_dac_on,
  input  logic              fe2_cmp_en,
  input  logic              fe2_dac_en,
  input  logic              tst_ovr,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [NCH-1:0]    result
);
  logic     rst_sync_n;
  fe_ctl_t  seq_ctl;
  fe_ctl_t  loc_ctl;
  logic [NCH-1:0] res_q;

  hyst_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    seq_ctl.cmp_on = seq_cmp_on;
    seq_ctl.dac_on = seq_dac_on;
    loc_ctl.cmp_on = fe2_cmp_en;
    loc_ctl.dac_on = fe2_dac_en;
  end

  for (genvar f = 0; f < NFE; f++) begin : g_fe
    logic [NREG*DW-1:0] refs;
    logic               act;

    hyst_ref_bank #(
      .DW    (DW),
      .NREG  (NREG),
      .NFE   (NFE),
      .FE_ID (f)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .we       (cfg_we),
      .addr     (cfg_addr),
      .wdata    (cfg_wdata),
      .ref_flat (refs)
    );

    hyst_fe_gate #(
      .HAS_LOCAL_EN (f != 0)
    ) u_gate (
      .seq_ctl (seq_ctl),
      .loc_en  (loc_ctl),
      .act     (act)
    );

    for (genvar k = 0; k < CPF; k++) begin : g_ch
      localparam int unsigned CH = f * CPF + k;

      hyst_channel #(
        .DW          (DW),
        .NREG        (NREG),
        .CH_K        (k),
        .TST_CAPABLE (f == 0)
      ) u_ch (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .ref_flat (refs),
        .sample   (samp_data[CH*DW +: DW]),
        .stb      (samp_strb[CH]),
        .act      (act),
        .tst      (tst_ovr),
        .res      (res_q[CH])
      );
    end
  end

  assign result = res_q;
endmodule

// File: rtl/hyst_cmp_bank_chk.sv
module hyst_cmp_bank_chk #(
  parameter int unsigned DW  = 12,
  parameter int unsigned CPF = 4,
  parameter int unsigned NCH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    samp_strb,
  input logic [NCH*DW-1:0] samp_data,
  input logic              seq_cmp_on,
  input logic              seq_dac_on,
  input logic              fe2_cmp_en,
  input logic              fe2_dac_en,
  input logic [NCH-1:0]    result
);
  AST_SEQ_OFF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_cmp_on || !seq_dac_on) |=> $stable(result)); // R7

  AST_FE2_OFF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fe2_cmp_en || !fe2_dac_en) |=> $stable(result[NCH-1:CPF])); // R8

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !samp_strb[i] |=> $stable(result[i])); // R6

    if (i < CPF) begin : g_fe1
      AST_FULLSCALE_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_strb[i] && seq_cmp_on && seq_dac_on && (samp_data[i*DW +: DW] == {DW{1'b1}}))
        |=> result[i]); // R5
    end
  end
endmodule

bind hyst_cmp_bank hyst_cmp_bank_chk #(
  .DW  (DW),
  .CPF (CPF),
  .NCH (NCH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .samp_strb  (samp_strb),
  .samp_data  (samp_data),
  .seq_cmp_on (seq_cmp_on),
  .seq_dac_on (seq_dac_on),
  .fe2_cmp_en (fe2_cmp_en),
  .fe2_dac_en (fe2_dac_en),
  .result     (result)
);

// File: tb/hyst_cmp_bank_test.sv
`timescale 1ns/1ps
module hyst_cmp_bank_test;
  localparam int DW  = 12;
  localparam int NCH = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NCH-1:0]    samp_strb;
  logic [NCH*DW-1:0] samp_data;
  logic              seq_cmp_on, seq_dac_on, fe2_cmp_en, fe2_dac_en, tst_ovr;
  logic              cfg_we;
  logic [3:0]        cfg_addr;
  logic [DW-1:0]     cfg_wdata;
  logic [NCH-1:0]    result;

  typedef struct {
    logic [NCH-1:0] exp;
    string          tag;
  } item_t;

  item_t sb[$];
  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0]  m_ref [2][8];
  logic [NCH-1:0] m_res;

  always #2.5 clk = ~clk;

  hyst_cmp_bank uut (
    .clk(clk), .rst_n(rst_n), .samp_strb(samp_strb), .samp_data(samp_data),
    .seq_cmp_on(seq_cmp_on), .seq_dac_on(seq_dac_on), .fe2_cmp_en(fe2_cmp_en),
    .fe2_dac_en(fe2_dac_en), .tst_ovr(tst_ovr), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .result(result)
  );

  task automatic check(input logic [NCH-1:0] act, input logic [NCH-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: result=%b expected=%b", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (sb.size() != 0) begin
      item_t it;
      it = sb.pop_front();
      check(result, it.exp, it.tag);
    end
  end

  // one cycle of stimulus; model reads thresholds before applying the write
  task automatic step(input logic [NCH-1:0] stb, input logic [NCH*DW-1:0] data,
                      input logic we, input logic [3:0] addr, input logic [DW-1:0] wd,
                      input string tag);
    item_t it;
    @(negedge clk);
    samp_strb = stb; samp_data = data;
    cfg_we = we; cfg_addr = addr; cfg_wdata = wd;
    for (int i = 0; i < NCH; i++) begin
      int fe, k, idx;
      logic act;
      fe  = i / 4;
      k   = i % 4;
      act = seq_cmp_on && seq_dac_on && ((fe == 0) || (fe2_cmp_en && fe2_dac_en));
      idx = ((fe == 0) && tst_ovr) ? (6 + int'(m_res[i])) : (2 * k + int'(m_res[i]));
      if (stb[i] && act) m_res[i] = (data[i*DW +: DW] >= m_ref[fe][idx]);
    end
    if (we) m_ref[addr[3]][addr[2:0]] = wd;
    @(posedge clk);
    #1;
    it.exp = m_res; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [3:0] addr, input logic [DW-1:0] wd, input string tag);
    step('0, '0, 1'b1, addr, wd, tag);
  endtask

  function automatic logic [NCH*DW-1:0] all_lanes(input logic [DW-1:0] v);
    logic [NCH*DW-1:0] d;
    for (int i = 0; i < NCH; i++) d[i*DW +: DW] = v;
    return d;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: result=%b expected=finish", result);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [NCH*DW-1:0] d;
    rst_n = 1'b0; samp_strb = '0; samp_data = '0;
    seq_cmp_on = 1'b1; seq_dac_on = 1'b1; fe2_cmp_en = 1'b1; fe2_dac_en = 1'b1;
    tst_ovr = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    m_res = '0;
    for (int f = 0; f < 2; f++) for (int r = 0; r < 8; r++) m_ref[f][r] = '0;
    repeat (3) @(negedge clk);
    check(result, '0, "R1 during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(result, '0, "R1 after reset");
    // R1: zero thresholds => sample 0 trips every channel
    step('1, all_lanes(12'd0), 1'b0, '0, '0, "R1 zero thresholds");
    // R3: load distinct code sets for both front-ends
    for (int r = 0; r < 8; r++) begin
      wr({1'b0, 3'(r)}, 12'(400 + 100 * r), "R3 write fe1");
      wr({1'b1, 3'(r)}, 12'(1000 + 50 * r), "R3 write fe2");
    end
    // R4 R5: stored=1 => odd codes; sweep per-lane samples
    for (int i = 0; i < NCH; i++) d[i*DW +: DW] = 12'(450 + 150 * i);
    step('1, d, 1'b0, '0, '0, "R4 odd code select");
    step('1, all_lanes(12'd0), 1'b0, '0, '0, "R5 below all codes");
    step('1, all_lanes(12'd600), 1'b0, '0, '0, "R4 even code select");
    step('1, all_lanes(12'd1100), 1'b0, '0, '0, "R5 mid sample");
    // R5 equality on channel 0 (stored 1 -> code 1 = 500)
    step(8'h01, all_lanes(12'd500), 1'b0, '0, '0, "R5 equal to code");
    step(8'h01, all_lanes(12'd499), 1'b0, '0, '0, "R5 one below code");
    // R2: single-lane strobes
    for (int i = 0; i < NCH; i++) step(NCH'(1) << i, all_lanes(12'd4095), 1'b0, '0, '0, "R2 lane map");
    // R6: no strobe, samples move
    step('0, all_lanes(12'd0), 1'b0, '0, '0, "R6 hold without strobe");
    // R7: sequencer switches
    seq_cmp_on = 1'b0;
    step('1, all_lanes(12'd0), 1'b0, '0, '0, "R7 comparator switch off");
    seq_cmp_on = 1'b1; seq_dac_on = 1'b0;
    step('1, all_lanes(12'd0), 1'b0, '0, '0, "R7 reference switch off");
    seq_dac_on = 1'b1;
    // R8: local enables of front-end 2
    fe2_cmp_en = 1'b0;
    step('1, all_lanes(12'd0), 1'b0, '0, '0, "R8 fe2 cmp disabled");
    fe2_cmp_en = 1'b1; fe2_dac_en = 1'b0;
    step('1, all_lanes(12'd4095), 1'b0, '0, '0, "R8 fe2 dac disabled");
    fe2_dac_en = 1'b1;
    step('1, all_lanes(12'd4095), 1'b0, '0, '0, "R8 fe2 re-enabled");
    // R9: override on fe1 (codes 6=1000, 7=1100)
    tst_ovr = 1'b1;
    step('1, all_lanes(12'd1050), 1'b0, '0, '0, "R9 override stored 1");
    step('1, all_lanes(12'd1050), 1'b0, '0, '0, "R9 override stored 0");
    step('1, all_lanes(12'd1000), 1'b0, '0, '0, "R9 override equal");
    tst_ovr = 1'b0;
    step('1, all_lanes(12'd750), 1'b0, '0, '0, "R9 override released");
    // R3: same-cycle write to the selected code
    step(8'h01, all_lanes(12'd0), 1'b0, '0, '0, "R3 setup clear ch0");
    step(8'h01, all_lanes(12'd300), 1'b1, 4'h0, 12'd200, "R3 same-cycle old code");
    step(8'h01, all_lanes(12'd250), 1'b0, '0, '0, "R3 new code used");
    step(8'h10, all_lanes(12'd0), 1'b0, '0, '0, "R3 setup clear ch4");
    step(8'h10, all_lanes(12'd900), 1'b1, 4'h8, 12'd2000, "R3 same-cycle fe2");
    // randomised traffic
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < NCH; i++) d[i*DW +: DW] = 12'($urandom_range(0, 2200));
      seq_cmp_on = ($urandom_range(0, 7) != 0);
      seq_dac_on = ($urandom_range(0, 7) != 0);
      fe2_cmp_en = ($urandom_range(0, 5) != 0);
      fe2_dac_en = ($urandom_range(0, 5) != 0);
      tst_ovr    = ($urandom_range(0, 4) == 0);
      step(NCH'($urandom), d, ($urandom_range(0, 3) == 0), 4'($urandom),
           12'($urandom_range(0, 2200)), "R5 random traffic");
    end
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule